// File: doc/BRIEF.md
# Parallel Multi-Register Pseudorandom Word Generator

The block produces a pseudorandom word for a randomized-frequency PWM controller. Three independent maximal-length linear feedback shift registers, of mutually prime lengths and each with its own primitive feedback polynomial, advance together on every enabled clock. The bit leaving each register is XOR-combined into one bit. That bit is shifted into the most significant end of a 16-bit stream register, so the stream changes on every enabled clock. Because the register periods are coprime, the combined bit sequence repeats only after the product of the three periods.

A single-cycle start-of-switching-cycle pulse captures the stream into an output word. The word is then held unchanged until the next pulse, and the bits produced in between are simply discarded. Each register can be reseeded on its own. A seed that is all zeros over the register's length is replaced by that register's nonzero default, so no register can lock up. The captured word has a valid flag with no back-pressure: the word is the current sample, every pulse overwrites it, and a consumer that does not take a word before the next pulse loses it.

Top module: `rand_word_gen`

## Requirements
- R1: Each register advances once per enabled clock as `s <= {^(s & TAPS), s[L-1:1]}`. The bit leaving the register is `s[0]`. The default taps are bits {0,3} for L=17, bits {0,1,2,5} for L=19 and bits {0,5} for L=23. A register started from any nonzero state has period 2^L-1.
- R2: On each clock with `en` high, the stream shifts right by one. The XOR of bit 0 of the three registers, taken before the edge, enters `stream[15]`.
- R3: With `en` low and no seed load, the registers and `stream` keep their values.
- R4: While `rst_n` is low, each register holds its own nonzero default, and `stream`, `word` and `word_valid` are zero.
- R5: When `seed_load[i]` is high, register i takes `seed_val[L_i-1:0]` at the edge. This overrides its step whatever `en` is, and it does not affect the other registers.
- R6: A seed whose low L_i bits are all zero loads register i's default, so no register ever holds zero.
- R7: When `cyc_start` is high at an edge, `word` takes the value `stream` had before that edge. This holds even when a seed load or a shift happens at the same edge. Otherwise `word` keeps its value.
- R8: `word_valid` goes high at the first `cyc_start` after reset and stays high.
- R9: With `en` held high, the stream sequence repeats with period equal to the product of the three register periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance registers and stream |
| seed_load | input | 3 | Per-register seed load strobe |
| seed_val | input | SW (23) | Seed value, low L_i bits used by register i |
| cyc_start | input | 1 | Start-of-switching-cycle pulse |
| stream | output | 16 | Continuously shifting combined word |
| word | output | 16 | Word captured at the last cycle start |
| word_valid | output | 1 | A word has been captured since reset |

## Verification
A cycle-start capture can land on the same edge as a reseed, and on the same edge as a stream shift. The bench drives `cyc_start` together with a `seed_load` and `en` high in one cycle. It expects `word` to equal the stream value from before that edge, while the reloaded register appears in the stream from the following edge on. The bench compares a cycle-level model of the small configuration (L = 3, 4, 5) against the outputs on every cycle, over more than one full combined period of 3255 cycles.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  localparam int unsigned NUM_REG = 3;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/lfsr_cell.sv
module lfsr_cell #(
  parameter int unsigned L    = 17,
  parameter logic [31:0] TAPS = 32'h9,
  parameter logic [31:0] DFLT = 32'h1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [L-1:0] seed,
  output logic [L-1:0] state
);
  localparam logic [L-1:0] MASK = TAPS[L-1:0];
  localparam logic [L-1:0] DEF  = DFLT[L-1:0];

  logic         fb;
  logic [L-1:0] nxt;
  logic [L-1:0] seed_ok;

  assign fb      = ^(state & MASK);
  assign nxt     = {fb, state[L-1:1]};
  assign seed_ok = (seed == '0) ? DEF : seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= DEF;
    else if (load) state <= seed_ok;
    else if (step) state <= nxt;
  end
endmodule

// File: rtl/mix_shift.sv
module mix_shift #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [N-1:0] bits,
  output logic [W-1:0] stream
);
  logic comb_bit;
  assign comb_bit = ^bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stream <= '0;
    else if (step) stream <= {comb_bit, stream[W-1:1]};
  end
endmodule

// File: rtl/cycle_sampler.sv
module cycle_sampler #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_start,
  input  logic [W-1:0] stream,
  output logic [W-1:0] word,
  output logic         word_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word       <= '0;
      word_valid <= 1'b0;
    end else if (cyc_start) begin
      word       <= stream;
      word_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/rand_word_gen.sv
module rand_word_gen
  import rwg_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LEN0   = 17,
  parameter int unsigned LEN1   = 19,
  parameter int unsigned LEN2   = 23,
  parameter logic [31:0] TAP0   = 32'h0000_0009,
  parameter logic [31:0] TAP1   = 32'h0000_0027,
  parameter logic [31:0] TAP2   = 32'h0000_0021,
  parameter logic [31:0] DFLT0  = 32'h0001_ACE1,
  parameter logic [31:0] DFLT1  = 32'h0005_3C27,
  parameter logic [31:0] DFLT2  = 32'h006B_1D05,
  localparam int unsigned SW    = max3(LEN0, LEN1, LEN2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        seed_load,
  input  logic [SW-1:0]     seed_val,
  input  logic              cyc_start,
  output logic [WORD_W-1:0] stream,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);
  logic [NUM_REG-1:0]         out_bits;
  logic [NUM_REG-1:0][SW-1:0] lfsr_st;

  for (genvar g = 0; g < NUM_REG; g++) begin : gen_cell
    localparam int unsigned L  = (g == 0) ? LEN0 : (g == 1) ? LEN1 : LEN2;
    localparam logic [31:0] TP = (g == 0) ? TAP0 : (g == 1) ? TAP1 : TAP2;
    localparam logic [31:0] DF = (g == 0) ? DFLT0 : (g == 1) ? DFLT1 : DFLT2;
    logic [L-1:0] q;

    lfsr_cell #(.L(L), .TAPS(TP), .DFLT(DF)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (en),
      .load  (seed_load[g]),
      .seed  (seed_val[L-1:0]),
      .state (q)
    );
    assign out_bits[g] = q[0];
    assign lfsr_st[g]  = SW'(q);
  end

  mix_shift #(.W(WORD_W), .N(NUM_REG)) u_mix (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (en),
    .bits   (out_bits),
    .stream (stream)
  );

  cycle_sampler #(.W(WORD_W)) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .stream     (stream),
    .word       (word),
    .word_valid (word_valid)
  );
endmodule

// File: rtl/rand_word_gen_chk.sv
module rand_word_gen_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned SW = 23,
  parameter int unsigned L0 = 17,
  parameter int unsigned L1 = 19,
  parameter int unsigned L2 = 23,
  parameter logic [31:0] D0 = 32'h1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic [2:0]          seed_load,
  input logic [SW-1:0]       seed_val,
  input logic                cyc_start,
  input logic [W-1:0]        stream,
  input logic [W-1:0]        word,
  input logic                word_valid,
  input logic [2:0][SW-1:0]  lfsr_st
);
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> stream[W-2:0] == $past(stream[W-1:1]));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(stream));

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> word == $past(stream));

  p_word_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_start |=> $stable(word));

  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> word_valid);

  p_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load[1] && seed_val[L1-1:0] != '0) |=>
      lfsr_st[1][L1-1:0] == $past(seed_val[L1-1:0]));

  p_zero_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load[0] && seed_val[L0-1:0] == '0) |=> lfsr_st[0][L0-1:0] == D0[L0-1:0]);

  p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_st[0] != '0 && lfsr_st[1] != '0 && lfsr_st[2] != '0);
endmodule

bind rand_word_gen rand_word_gen_chk #(
  .W(WORD_W), .SW(SW), .L0(LEN0), .L1(LEN1), .L2(LEN2), .D0(DFLT0)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .seed_load  (seed_load),
  .seed_val   (seed_val),
  .cyc_start  (cyc_start),
  .stream     (stream),
  .word       (word),
  .word_valid (word_valid),
  .lfsr_st    (lfsr_st)
);

// File: tb/rand_word_gen_tb.sv
module rand_word_gen_tb;
  localparam int W  = 16;
  localparam int SW = 5;
  localparam int PERIOD = 7 * 15 * 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [2:0]    seed_load = '0;
  logic [SW-1:0] seed_val = '0;
  logic          cyc_start = 1'b0;
  logic [W-1:0]  stream, word;
  logic          word_valid;

  always #10 clk = ~clk;

  rand_word_gen #(
    .WORD_W(16), .LEN0(3), .LEN1(4), .LEN2(5),
    .TAP0(32'h3), .TAP1(32'h3), .TAP2(32'h5),
    .DFLT0(32'h5), .DFLT1(32'h9), .DFLT2(32'h13)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load), .seed_val(seed_val),
    .cyc_start(cyc_start), .stream(stream), .word(word), .word_valid(word_valid)
  );

  int checks = 0, fails = 0;
  int err_s, err_w, err_v;
  logic [31:0] m [3];
  logic [W-1:0] ms, mw;
  logic mv;

  function automatic int lenof(input int i);
    return (i == 0) ? 3 : (i == 1) ? 4 : 5;
  endfunction
  function automatic logic [31:0] maskof(input int i);
    return (i == 0) ? 32'h3 : (i == 1) ? 32'h3 : 32'h5;
  endfunction
  function automatic logic [31:0] defof(input int i);
    return (i == 0) ? 32'h5 : (i == 1) ? 32'h9 : 32'h13;
  endfunction
  function automatic logic [31:0] adv(input logic [31:0] s, input int i);
    logic fb;
    fb = ^(s & maskof(i));
    return (s >> 1) | ({31'b0, fb} << (lenof(i) - 1));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_err();
    err_s = 0; err_w = 0; err_v = 0;
  endtask

  task automatic tick(input bit e, input logic [2:0] ld, input logic [SW-1:0] sv,
                      input bit cs);
    logic cb;
    logic [31:0] sm;
    en = e; seed_load = ld; seed_val = sv; cyc_start = cs;
    @(posedge clk);
    cb = m[0][0] ^ m[1][0] ^ m[2][0];
    if (cs) begin mw = ms; mv = 1'b1; end
    if (e) ms = {cb, ms[W-1:1]};
    for (int i = 0; i < 3; i++) begin
      sm = {27'b0, sv} & ((32'h1 << lenof(i)) - 1);
      if (ld[i]) m[i] = (sm == 0) ? defof(i) : sm;
      else if (e) m[i] = adv(m[i], i);
    end
    @(negedge clk);
    if (stream !== ms) err_s++;
    if (word !== mw) err_w++;
    if (word_valid !== mv) err_v++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] rec [20];
    logic [W-1:0] held;
    int err_p;
    for (int i = 0; i < 3; i++) m[i] = defof(i);
    ms = '0; mw = '0; mv = 1'b0;
    repeat (3) @(negedge clk);
    // R4: reset state
    check(stream == '0, "R4 stream reset", 32'(stream), 0);
    check(word == '0, "R4 word reset", 32'(word), 0);
    check(word_valid == 1'b0, "R4 valid reset", 32'(word_valid), 0);
    rst_n = 1'b1;

    // R1: period of each register polynomial from a nonzero start
    for (int i = 0; i < 3; i++) begin
      logic [31:0] s;
      int n;
      s = adv(defof(i), i);
      n = 1;
      while (s != defof(i) && n < 100) begin s = adv(s, i); n++; end
      check(n == (1 << lenof(i)) - 1, "R1 register period", n, (1 << lenof(i)) - 1);
    end

    // R1/R2/R7/R8/R9: free run over more than one combined period
    clear_err(); err_p = 0;
    for (int c = 0; c < PERIOD + 100; c++) begin
      tick(1'b1, 3'b000, '0, (c % 7) == 3);
      if (c >= 50 && c < 70) rec[c - 50] = stream;
      if (c >= 50 + PERIOD && c < 70 + PERIOD && stream !== rec[c - 50 - PERIOD]) err_p++;
    end
    check(err_s == 0, "R1 R2 stream mismatches", err_s, 0);
    check(err_w == 0, "R7 word mismatches", err_w, 0);
    check(err_v == 0, "R8 valid mismatches", err_v, 0);
    check(err_p == 0, "R9 period repeat mismatches", err_p, 0);

    // R3: enable low freezes stream while capture still works
    clear_err();
    held = stream;
    for (int c = 0; c < 20; c++) tick(1'b0, 3'b000, '0, (c % 5) == 0);
    check(stream == held && err_s == 0, "R3 stream frozen", 32'(stream), 32'(held));
    check(err_w == 0, "R3 R7 capture while disabled", err_w, 0);

    // R5: reseed one register only
    clear_err();
    tick(1'b1, 3'b010, 5'h0B, 1'b0);
    for (int c = 0; c < 60; c++) tick(1'b1, 3'b000, '0, (c % 9) == 0);
    check(err_s == 0 && err_w == 0, "R5 single reseed", err_s + err_w, 0);

    // R6: all-zero seed loads defaults
    clear_err();
    tick(1'b1, 3'b111, 5'h00, 1'b0);
    for (int c = 0; c < 60; c++) tick(1'b1, 3'b000, '0, (c % 11) == 0);
    check(err_s == 0, "R6 zero seed replaced", err_s, 0);

    // R7 concurrency: capture, reseed and shift on one edge
    clear_err();
    tick(1'b1, 3'b000, '0, 1'b0);
    held = stream;
    tick(1'b1, 3'b101, 5'h16, 1'b1);
    check(word == held, "R7 capture with reseed", 32'(word), 32'(held));
    for (int c = 0; c < 40; c++) tick(1'b1, 3'b000, '0, (c % 6) == 0);
    check(err_s == 0 && err_w == 0, "R5 R7 after concurrent reseed", err_s + err_w, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule